// File: doc/BRIEF.md
# Masked Slave Address Matcher

This block sits beside the receive shifter of a two-wire bus slave and decides, once a full address byte has been shifted in, whether that byte targets this node. The seven upper bits of the received byte are compared against a programmed node address. A per-bit mask lets chosen address bits be treated as "don't care". The all-zero broadcast (general call) address is recognised only when enabled. The lowest bit of the byte gives the transfer direction.

The same block also produces the acknowledge decision for the ninth clock. For an address byte it acknowledges an own-address match or an accepted broadcast. For a data byte it acknowledges when the node is acting as a receiver. Clearing the acknowledge enable detaches the node: addresses are neither matched nor acknowledged.

All results are registered on a strobe raised at the eighth bit-tick, so they are stable for the whole acknowledge clock. They hold until the next strobe.

Top module: `slave_addr_match`

## Requirements
- R1: On an address strobe with acknowledge enable high, `addr_hit` is set when the received bits 7:1 equal `own_cfg` bits 7:1 in every position whose mask bit is zero, and the received address field is not all zeros.
- R2: A mask bit of one in `mask_cfg` bit k (k = 7..1) removes received bit k from the compare, so a difference there does not clear `addr_hit`.
- R3: `gcall_hit` is set only when the received byte is 0x00 and `own_cfg` bit 0 (broadcast enable) is one. The all-zero address field never produces `addr_hit`, so at most one of the two is high.
- R4: `dir_read` takes received bit 0 (1 = read) on every address strobe, and that bit never takes part in the address compare.
- R5: After an address strobe, `ack_out` is high exactly when `addr_hit` or `gcall_hit` is high.
- R6: After a data strobe (`data_tick` without `addr_tick`), `ack_out` equals acknowledge enable AND `rx_role`, where `rx_role` = 1 means the node is the receiving side (master receiver or slave receiver). `addr_hit`, `gcall_hit` and `dir_read` keep their values.
- R7: With acknowledge enable low at an address strobe, `addr_hit`, `gcall_hit` and `ack_out` all go low.
- R8: Outputs change only in the cycle after a strobe and are held unchanged while neither strobe is high.
- R9: `mask_rd` returns `mask_cfg` bits 7:1 with bit 0 always zero.
- R10: After reset, `addr_hit`, `gcall_hit`, `dir_read` and `ack_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_cfg | input | 8 | Node address in bits 7:1, broadcast enable in bit 0 |
| mask_cfg | input | 8 | Per-bit compare mask for bits 7:1, bit 0 unused |
| ack_en | input | 1 | Acknowledge enable |
| rx_byte | input | 8 | Byte assembled by the receive shifter |
| addr_tick | input | 1 | Strobe: eighth bit of an address byte received |
| data_tick | input | 1 | Strobe: eighth bit of a data byte received |
| rx_role | input | 1 | Node is the receiving side of the current transfer |
| addr_hit | output | 1 | Own-address match |
| gcall_hit | output | 1 | Broadcast address accepted |
| dir_read | output | 1 | Direction bit of the last address (1 = read) |
| ack_out | output | 1 | Drive ACK on the ninth clock |
| mask_rd | output | 8 | Mask readback, bit 0 forced to zero |

## Verification
Address strobes are driven from a vector table covering several patterns. An exact match and a single-bit mismatch show that every unmasked bit counts. A difference under a set mask bit and an all-ones mask show that masked bits are ignored. Bytes with only the low bit differing show that direction is kept out of the compare. The zero byte is tried with broadcast enabled and disabled, including under a full mask, to separate broadcast from own-address matching. Directed sequences then vary acknowledge enable and receiver role on data strobes, check that held results survive idle cycles with changing inputs, and check the reset state and the mask readback.

// File: rtl/slave_addr_match.sv
module slave_addr_match #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] own_cfg,
  input  logic [AW:0] mask_cfg,
  input  logic        ack_en,
  input  logic [AW:0] rx_byte,
  input  logic        addr_tick,
  input  logic        data_tick,
  input  logic        rx_role,
  output logic        addr_hit,
  output logic        gcall_hit,
  output logic        dir_read,
  output logic        ack_out,
  output logic [AW:0] mask_rd
);

  logic [AW-1:0] diff;
  logic          zero_field, own_eq, gc_eq;

  assign diff       = (rx_byte[AW:1] ^ own_cfg[AW:1]) & ~mask_cfg[AW:1];
  assign zero_field = (rx_byte[AW:1] == '0);
  assign own_eq     = ack_en && (diff == '0) && !zero_field;
  assign gc_eq      = ack_en && own_cfg[0] && zero_field && !rx_byte[0];
  assign mask_rd    = {mask_cfg[AW:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hit  <= 1'b0;
      gcall_hit <= 1'b0;
      dir_read  <= 1'b0;
      ack_out   <= 1'b0;
    end else if (addr_tick) begin
      addr_hit  <= own_eq;
      gcall_hit <= gc_eq;
      dir_read  <= rx_byte[0];
      ack_out   <= own_eq || gc_eq;
    end else if (data_tick) begin
      ack_out   <= ack_en && rx_role;
    end
  end

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_hit, gcall_hit}));

  assert_gc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_tick && !own_cfg[0]) |=> !gcall_hit);

  assert_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_tick |=> (dir_read == $past(rx_byte[0])));

  assert_ack_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_tick |=> (ack_out == (addr_hit || gcall_hit)));

  assert_ack_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_tick && !addr_tick) |=> (ack_out == ($past(ack_en) && $past(rx_role))));

  assert_detach_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_tick && !ack_en) |=> (!addr_hit && !gcall_hit && !ack_out));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_tick && !data_tick) |=> $stable({addr_hit, gcall_hit, dir_read, ack_out}));

endmodule

// File: tb/sim_slave_addr_match.sv
module sim_slave_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] own_cfg = '0, mask_cfg = '0, rx_byte = '0, mask_rd;
  logic ack_en = 1'b0, addr_tick = 1'b0, data_tick = 1'b0, rx_role = 1'b0;
  logic addr_hit, gcall_hit, dir_read, ack_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slave_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .own_cfg(own_cfg), .mask_cfg(mask_cfg),
    .ack_en(ack_en), .rx_byte(rx_byte), .addr_tick(addr_tick),
    .data_tick(data_tick), .rx_role(rx_role), .addr_hit(addr_hit),
    .gcall_hit(gcall_hit), .dir_read(dir_read), .ack_out(ack_out),
    .mask_rd(mask_rd));

  // own, mask, ack_en, rx, {hit, gc, dir, ack}
  typedef struct packed {
    logic [7:0] own; logic [7:0] msk; logic en; logic [7:0] rx; logic [3:0] exp;
  } vec_t;
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{8'hA0, 8'h00, 1'b1, 8'hA0, 4'b1001},
    '{8'hA0, 8'h00, 1'b1, 8'hA1, 4'b1011},
    '{8'hA0, 8'h00, 1'b1, 8'hA2, 4'b0000},
    '{8'hA0, 8'h02, 1'b1, 8'hA2, 4'b1001},
    '{8'hA0, 8'h02, 1'b1, 8'hA4, 4'b0000},
    '{8'hA0, 8'hFE, 1'b1, 8'h5A, 4'b1001},
    '{8'hA1, 8'h00, 1'b1, 8'h00, 4'b0101},
    '{8'hA0, 8'h00, 1'b1, 8'h00, 4'b0000},
    '{8'hA1, 8'hFE, 1'b1, 8'h00, 4'b0101},
    '{8'hA0, 8'hFE, 1'b1, 8'h00, 4'b0000},
    '{8'hA0, 8'h00, 1'b0, 8'hA0, 4'b0000},
    '{8'hA1, 8'h00, 1'b0, 8'h00, 4'b0000},
    '{8'h01, 8'h00, 1'b1, 8'h01, 4'b0010},
    '{8'hE4, 8'h80, 1'b1, 8'h64, 4'b1001}
  };
  localparam string VTAG [NV] = '{"R1","R4","R1","R2","R2","R2","R3","R3",
                                  "R3","R3","R7","R7","R3","R2"};

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hit,gc,dir,ack} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic addr_strobe(input logic [7:0] own, input logic [7:0] msk,
                             input logic en, input logic [7:0] rx);
    own_cfg = own; mask_cfg = msk; ack_en = en; rx_byte = rx; addr_tick = 1'b1;
    @(negedge clk);
    addr_tick = 1'b0;
  endtask

  task automatic data_strobe(input logic en, input logic role);
    ack_en = en; rx_role = role; data_tick = 1'b1;
    @(negedge clk);
    data_tick = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {addr_hit, gcall_hit, dir_read, ack_out};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", outs(), 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", outs(), 4'b0000);

    for (int i = 0; i < NV; i++) begin
      addr_strobe(VT[i].own, VT[i].msk, VT[i].en, VT[i].rx);
      chk(VTAG[i], outs(), VT[i].exp);
    end

    // R5: address ack follows match, then R6 data acks
    addr_strobe(8'hA0, 8'h00, 1'b1, 8'hA0);
    chk("R5 addr ack", outs(), 4'b1001);
    data_strobe(1'b1, 1'b1);
    chk("R6 data ack receiver", outs(), 4'b1001);
    data_strobe(1'b1, 1'b0);
    chk("R6 no ack as transmitter", outs(), 4'b1000);
    data_strobe(1'b0, 1'b1);
    chk("R6 no ack when disabled", outs(), 4'b1000);
    data_strobe(1'b1, 1'b1);
    chk("R6 ack restored", outs(), 4'b1001);

    // R8: idle cycles with changing inputs keep outputs
    own_cfg = 8'h00; mask_cfg = 8'hFE; rx_byte = 8'h00; ack_en = 1'b0; rx_role = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 hold while idle", outs(), 4'b1001);

    // R9: mask readback
    mask_cfg = 8'hFF; #1;
    checks++;
    if (mask_rd !== 8'hFE) begin
      errors++; $display("FAIL R9: mask_rd actual %h expected fe", mask_rd);
    end
    mask_cfg = 8'h55; #1;
    checks++;
    if (mask_rd !== 8'h54) begin
      errors++; $display("FAIL R9: mask_rd actual %h expected 54", mask_rd);
    end

    // R7 after a hit: disabling clears everything
    addr_strobe(8'hA0, 8'h00, 1'b1, 8'hA1);
    chk("R4 read hit", outs(), 4'b1011);
    addr_strobe(8'hA0, 8'h00, 1'b0, 8'hA1);
    chk("R7 detach clears", outs(), 4'b0010);

    // R10 mid-run reset
    addr_strobe(8'hA1, 8'h00, 1'b1, 8'h00);
    rst_n = 1'b0; #1;
    chk("R10 reset mid-run", outs(), 4'b0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule